// File: doc/BRIEF.md
# Integer ALU Status Flag Generator

This block sits beside an integer execution unit. It produces the arithmetic status flags for one add, subtract or logic operation per clock. The unit supplies both operands, the result it computed, the kind of operation and the operand size, which is 8, 16, 32 or 64 bits. From these the block derives five status bits:

- carry
- parity
- zero
- sign
- overflow

It keeps them in a 64-bit flags register with a fixed bit layout, and that register is the block's only output.

A separate pair of inputs sets or clears the direction bit, which string-move sequencers use to choose whether their pointers step up or down. No other path writes the register. Bits outside the implemented set read as constants: bit 1 is always 1 and every other unused bit is 0. All result-derived flags look only at the part of the operands and result selected by the size input. Parity is the exception, because it always examines only the lowest result byte.

Top module: `alu_status_flags`

## Requirements
- R1: While rst_n is low, and at the first clock after rst_n rises, flagsOut reads 64'h0000_0000_0000_0002.
- R2: For an add (opKind 0), the carry bit (bit 0) is 1 exactly when the unsigned sum of the two operands, truncated to the selected size, overflows that size. The size encoding is opSize 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits.
- R3: For a subtract (opKind 1), the carry bit is 1 exactly when opA is unsigned-less than opB within the selected size, which is the borrow case.
- R4: The overflow bit (bit 11) is set in two cases at the selected size:
  - an add whose two operands share a sign bit that differs from the result's sign bit;
  - a subtract whose operands differ in sign and whose result's sign differs from opA's sign.
- R5: The parity bit (bit 2) is 1 when opResult[7:0] holds an even number of 1 bits, whatever the size.
- R6: The zero bit (bit 6) is 1 when the result truncated to the size is all zeros. The sign bit (bit 7) equals the top bit of that truncated result. Result bits above the size have no effect.
- R7: A logic operation (opKind 2 or 3) clears both carry and overflow.
- R8: An update with flagWe high loads bits 0, 2, 6, 7 and 11 at the next rising clock edge. With flagWe low, those bits keep their values.
- R9: The direction bit (bit 10) goes to 1 at the next edge when dirSet is high. It goes to 0 when dirClr is high and dirSet is low. Otherwise it holds. A status update never changes it.
- R10: Bit 1 always reads 1. Bits 3, 4, 5, 8, 9 and 12 to 63 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| flagWe | input | 1 | Load the status bits from this cycle's operation |
| opKind | input | 2 | 0 add, 1 subtract, 2 or 3 logic |
| opSize | input | 2 | 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| opResult | input | 64 | Result produced by the execution unit |
| dirSet | input | 1 | Set the direction bit |
| dirClr | input | 1 | Clear the direction bit (set wins) |
| flagsOut | output | 64 | Flags register |

## Verification
Every flag lives in one register that drives flagsOut directly, so a wrong next-state value shows at the port one clock after the operation that caused it. A value that is wrongly held or lost shows at the first later read, and idle cycles expose it because the bench expects the word to stay constant. A fault in a single size lane hides until an operation of that size arrives. For that reason the bench mixes all four sizes, with junk placed above the operand size. The scoreboard compares the whole 64-bit word every cycle, so a stray write into a reserved bit or into the direction bit is caught on the very next edge.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int FLAG_W  = 64;
  localparam int NUM_SZ  = 4;
  localparam int CF_POS  = 0;
  localparam int ONE_POS = 1;
  localparam int PF_POS  = 2;
  localparam int ZF_POS  = 6;
  localparam int SF_POS  = 7;
  localparam int DF_POS  = 10;
  localparam int OF_POS  = 11;
  localparam logic [FLAG_W-1:0] FIXED_ONES = FLAG_W'(1) << ONE_POS;
  localparam logic [FLAG_W-1:0] STATUS_MASK =
    (FLAG_W'(1) << CF_POS) | (FLAG_W'(1) << PF_POS) | (FLAG_W'(1) << ZF_POS) |
    (FLAG_W'(1) << SF_POS) | (FLAG_W'(1) << OF_POS);
  localparam logic [FLAG_W-1:0] LIVE_MASK = STATUS_MASK | (FLAG_W'(1) << DF_POS);
  localparam logic [FLAG_W-1:0] RESET_FLAGS = FIXED_ONES;

  typedef enum logic [1:0] {KIND_ADD = 2'd0, KIND_SUB = 2'd1,
                            KIND_AND = 2'd2, KIND_XOR = 2'd3} opKind_e;

  typedef struct packed {
    logic loadStatus;
    logic setDir;
    logic clrDir;
  } flagStrobe_t;

  typedef struct packed {
    logic carry;
    logic zero;
    logic sign;
    logic overflow;
  } laneFlags_t;
endpackage

// File: rtl/flag_lane.sv
module flag_lane
  import alu_flag_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [1:0]        kind,
  input  logic [LANE_W-1:0] laneA,
  input  logic [LANE_W-1:0] laneB,
  input  logic [LANE_W-1:0] laneR,
  output laneFlags_t        laneOut
);
  localparam int MSB = LANE_W - 1;

  logic [LANE_W:0] wideSum;
  logic signA, signB, signR;

  assign wideSum = {1'b0, laneA} + {1'b0, laneB};
  assign signA = laneA[MSB];
  assign signB = laneB[MSB];
  assign signR = laneR[MSB];

  always_comb begin
    laneOut.zero = (laneR == '0);
    laneOut.sign = signR;
    unique case (opKind_e'(kind))
      KIND_ADD: begin
        laneOut.carry    = wideSum[LANE_W];
        laneOut.overflow = (signA == signB) && (signR != signA);
      end
      KIND_SUB: begin
        laneOut.carry    = (laneA < laneB);
        laneOut.overflow = (signA != signB) && (signR != signA);
      end
      default: begin
        laneOut.carry    = 1'b0;
        laneOut.overflow = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import alu_flag_pkg::*;
(
  input  logic        flagWe,
  input  logic        dirSet,
  input  logic        dirClr,
  output flagStrobe_t strobe
);
  always_comb begin
    strobe.loadStatus = flagWe;
    strobe.setDir     = dirSet;
    strobe.clrDir     = dirClr & ~dirSet;
  end
endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import alu_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  flagStrobe_t       strobe,
  input  logic [1:0]        opKind,
  input  logic [1:0]        opSize,
  input  logic [FLAG_W-1:0] opA,
  input  logic [FLAG_W-1:0] opB,
  input  logic [FLAG_W-1:0] opResult,
  output logic [FLAG_W-1:0] flagsQ
);
  laneFlags_t laneSet [NUM_SZ];
  laneFlags_t picked;
  logic parityEven;
  logic [FLAG_W-1:0] flagsNext;

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_lane
    localparam int LW = 8 << g;
    flag_lane #(.LANE_W(LW)) u_lane (
      .kind   (opKind),
      .laneA  (opA[LW-1:0]),
      .laneB  (opB[LW-1:0]),
      .laneR  (opResult[LW-1:0]),
      .laneOut(laneSet[g])
    );
  end

  assign picked     = laneSet[opSize];
  assign parityEven = ~^opResult[7:0];

  always_comb begin
    flagsNext = flagsQ;
    if (strobe.loadStatus) begin
      flagsNext[CF_POS] = picked.carry;
      flagsNext[PF_POS] = parityEven;
      flagsNext[ZF_POS] = picked.zero;
      flagsNext[SF_POS] = picked.sign;
      flagsNext[OF_POS] = picked.overflow;
    end
    if (strobe.setDir)      flagsNext[DF_POS] = 1'b1;
    else if (strobe.clrDir) flagsNext[DF_POS] = 1'b0;
    flagsNext = (flagsNext & LIVE_MASK) | FIXED_ONES;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flagsQ <= RESET_FLAGS;
    else        flagsQ <= flagsNext;
  end

  assert_logic_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadStatus && opKind[1] |=> !flagsQ[CF_POS] && !flagsQ[OF_POS]);

  assert_parity_zero_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadStatus && (opResult[7:0] == 8'h00) |=> flagsQ[PF_POS]);

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadStatus && !strobe.setDir && !strobe.clrDir |=> $stable(flagsQ));

  assert_dir_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.setDir |=> flagsQ[DF_POS]);

  assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.setDir && !strobe.clrDir |=> $stable(flagsQ[DF_POS]));

  assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flagsQ[ONE_POS] && ((flagsQ & ~(LIVE_MASK | FIXED_ONES)) == '0));
endmodule

// File: rtl/alu_status_flags.sv
module alu_status_flags
  import alu_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flagWe,
  input  logic [1:0]  opKind,
  input  logic [1:0]  opSize,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic [63:0] opResult,
  input  logic        dirSet,
  input  logic        dirClr,
  output logic [63:0] flagsOut
);
  flagStrobe_t strobe;

  flag_ctrl u_ctrl (
    .flagWe(flagWe),
    .dirSet(dirSet),
    .dirClr(dirClr),
    .strobe(strobe)
  );

  flag_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .opKind  (opKind),
    .opSize  (opSize),
    .opA     (opA),
    .opB     (opB),
    .opResult(opResult),
    .flagsQ  (flagsOut)
  );
endmodule

// File: tb/alu_status_flags_test.sv
`timescale 1ns/1ps
module alu_status_flags_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flagWe = 1'b0;
  logic [1:0] opKind = 2'd0;
  logic [1:0] opSize = 2'd0;
  logic [63:0] opA = '0, opB = '0, opResult = '0;
  logic dirSet = 1'b0, dirClr = 1'b0;
  logic [63:0] flagsOut;

  typedef struct {
    logic [63:0] want;
    string       tag;
  } item_t;

  item_t sbq[$];
  logic [63:0] model = 64'h2;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  alu_status_flags uut (
    .clk(clk), .rst_n(rst_n), .flagWe(flagWe), .opKind(opKind), .opSize(opSize),
    .opA(opA), .opB(opB), .opResult(opResult), .dirSet(dirSet), .dirClr(dirClr),
    .flagsOut(flagsOut)
  );

  function automatic logic [63:0] predict(logic [63:0] prev, logic we, logic [1:0] k,
      logic [1:0] sz, logic [63:0] a, logic [63:0] b, logic [63:0] r, logic ds, logic dc);
    int w;
    logic [63:0] m, am, bm, rm;
    logic [64:0] s;
    logic sa, sb, sr, cf, of;
    logic [63:0] n;
    w  = 8 << sz;
    m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    am = a & m; bm = b & m; rm = r & m;
    s  = {1'b0, am} + {1'b0, bm};
    sa = am[w-1]; sb = bm[w-1]; sr = rm[w-1];
    cf = 1'b0; of = 1'b0;
    if (k == 2'd0) begin cf = s[w]; of = (sa == sb) && (sr != sa); end
    else if (k == 2'd1) begin cf = am < bm; of = (sa != sb) && (sr != sa); end
    n = prev;
    if (we) begin
      n[0] = cf; n[2] = ~^r[7:0]; n[6] = (rm == 0); n[7] = sr; n[11] = of;
    end
    if (ds) n[10] = 1'b1;
    else if (dc) n[10] = 1'b0;
    return n;
  endfunction

  task automatic step(logic we, logic [1:0] k, logic [1:0] sz, logic [63:0] a,
                      logic [63:0] b, logic ds, logic dc, string tag);
    logic [63:0] r;
    @(negedge clk);
    case (k)
      2'd0: r = a + b;
      2'd1: r = a - b;
      2'd2: r = a & b;
      default: r = a ^ b;
    endcase
    flagWe = we; opKind = k; opSize = sz; opA = a; opB = b; opResult = r;
    dirSet = ds; dirClr = dc;
    model = predict(model, we, k, sz, a, b, r, ds, dc);
    sbq.push_back('{want: model, tag: tag});
  endtask

  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (flagsOut !== it.want) begin
        errors++;
        $display("FAIL %s: flags=%h expected=%h", it.tag, flagsOut, it.want);
      end
    end
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (flagsOut !== 64'h2) begin
      errors++;
      $display("FAIL R1 in reset: flags=%h expected=%h", flagsOut, 64'h2);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (flagsOut !== 64'h2) begin
      errors++;
      $display("FAIL R1 after reset: flags=%h expected=%h", flagsOut, 64'h2);
    end
    step(1, 2'd0, 2'd0, 64'hFF, 64'h01, 0, 0, "R2 add8 carry+zero");
    step(1, 2'd0, 2'd0, 64'h7F, 64'h01, 0, 0, "R4 add8 overflow");
    step(1, 2'd1, 2'd1, 64'h0, 64'h1, 0, 0, "R3 sub16 borrow");
    step(1, 2'd1, 2'd0, 64'h80, 64'h01, 0, 0, "R4 sub8 overflow");
    step(1, 2'd1, 2'd2, 64'h5, 64'h5, 0, 0, "R6 sub32 zero");
    step(1, 2'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, "R2 add64 carry");
    step(1, 2'd0, 2'd1, 64'hABCD_0000_1234_8000, 64'h0F00_0000_0000_8000, 0, 0, "R6 add16 truncation");
    step(1, 2'd3, 2'd2, 64'h00FF_0001, 64'h0000_0002, 0, 0, "R5 parity low byte");
    step(1, 2'd0, 2'd0, 64'hFF, 64'h01, 0, 0, "R2 prime carry");
    step(1, 2'd2, 2'd3, 64'h8000_0000_0000_00F0, 64'hFFFF_0000_0000_00FF, 0, 0, "R7 logic clears");
    step(0, 2'd0, 2'd0, 64'hFF, 64'h01, 0, 0, "R8 hold");
    step(0, 2'd1, 2'd3, 64'h0, 64'h7, 0, 0, "R8 hold again");
    step(0, 2'd0, 2'd0, 64'h0, 64'h0, 1, 0, "R9 dir set");
    step(1, 2'd1, 2'd0, 64'h1, 64'h2, 0, 0, "R9 update keeps dir");
    step(0, 2'd0, 2'd0, 64'h0, 64'h0, 0, 1, "R9 dir clear");
    step(1, 2'd0, 2'd1, 64'h7FFF, 64'h1, 1, 1, "R9 set wins with update");
    step(0, 2'd0, 2'd0, 64'h0, 64'h0, 0, 0, "R10 idle reserved");
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 5 == 0) b = a;
      step(($urandom % 4) != 0, 2'($urandom), 2'($urandom), a, b,
           ($urandom % 7) == 0, ($urandom % 6) == 0, "R2 R3 R4 R5 R6 random");
    end
    step(0, 2'd0, 2'd0, 64'h0, 64'h0, 0, 0, "R8 drain");
    repeat (3) @(negedge clk);
    checks++;
    if (flagsOut[1] !== 1'b1 || (flagsOut & ~64'hCC7) !== 64'h0) begin
      errors++;
      $display("FAIL R10 reserved bits: flags=%h expected mask=%h", flagsOut, 64'hCC7);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule